// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block carries out the word-sized atomic instructions of an integer core: read-modify-write operations (swap, add, bitwise xor/and/or, signed and unsigned minimum and maximum) and the load-reserved / store-conditional pair. The core hands over an already-decoded 5-bit operation code, the address taken from rs1, the rs2 operand and the destination register index. The block then drives a single memory port, first with a read and then, if the operation calls for it, with a write to the same address. It returns a writeback value, a writeback enable and a one-cycle completion pulse.

The register width XLEN is a parameter, either 32 or 64. The memory word is always 32 bits. The value that returns to the register file is the old memory word, sign-extended to XLEN. One reservation is held, consisting of an address and a valid bit. Load-reserved sets it. Every store-conditional consumes it, whether the store succeeds or fails. The acquire and release ordering bits travel with each request, but the block does not act on them.

The memory port has a fixed read latency of one cycle: read data requested in one cycle is presented on `mem_rdata` in the next. Writes take effect at the clock edge that ends the cycle in which `mem_wr_en` is high.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle: `op_ready` is 1, and `mem_rd_en`, `mem_wr_en`, `op_done` and `wb_en` are 0. No reservation is held, so a store-conditional issued first fails.
- R2: A request is accepted at a rising edge where `op_valid` and `op_ready` are both high. The read cycle follows with `mem_rd_en` high and `mem_addr` set to the request address. Any write comes in the cycle after that. `op_done` pulses in the third cycle after acceptance. `op_ready` is low from acceptance until `op_done` has been seen.
- R3: Codes 00001 (swap), 00000 (add), 00100 (xor), 01100 (and) and 01000 (or) write to memory the old word combined with the low 32 bits of rs2. For swap the written value is the rs2 word itself, and addition wraps modulo 2^32.
- R4: Codes 10000 (signed min) and 10100 (signed max) compare the old word and the rs2 word as two's complement numbers. Codes 11000 (unsigned min) and 11100 (unsigned max) compare them as unsigned numbers. The selected word is stored.
- R5: For every read-modify-write code, and for load-reserved, `wb_data` is the old 32-bit memory word sign-extended to XLEN.
- R6: Load-reserved (code 00010) returns the word, leaves memory unchanged and records a reservation on the request address.
- R7: Store-conditional (code 00011) to the reserved address writes the low 32 bits of rs2 and returns 0.
- R8: Store-conditional without a reservation, or to a different address, leaves memory unchanged and returns 1.
- R9: Every store-conditional clears the reservation, whether it succeeds or fails.
- R10: When the rd index is 0, `wb_en` stays low for the whole operation, but the memory write still takes place.
- R11: The acquire and release bits have no effect on the memory result, the writeback or the timing.
- R12: A code outside the listed set completes with the normal `op_done` timing. It performs no memory write and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Unit idle, so a request can be accepted |
| op_code | input | 5 | Decoded operation code |
| op_aq | input | 1 | Acquire bit (no effect) |
| op_rl | input | 1 | Release bit (no effect) |
| op_addr | input | XLEN | Byte address from rs1 |
| op_src | input | XLEN | rs2 operand; only the low 32 bits are used |
| op_rd | input | 5 | Destination register index |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd_en` |
| op_done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register writeback enable |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | XLEN | Writeback value |

## Verification
Once a request is accepted, the read cycle comes one cycle later, a write (if any) two cycles later, and the completion pulse with the writeback value three cycles later. The bench drives requests on falling edges and counts falling edges until `op_done` appears, expecting exactly three. It samples `wb_en` and `wb_data` on that same falling edge. The bench's memory model has then already absorbed the write, so the stored word can be compared on the same edge. On every intermediate falling edge the bench also confirms that `op_ready` is low and that `wb_en` has not asserted early.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [4:0] {
    AMO_ADD  = 5'b00000,
    AMO_SWAP = 5'b00001,
    AMO_LR   = 5'b00010,
    AMO_SC   = 5'b00011,
    AMO_XOR  = 5'b00100,
    AMO_OR   = 5'b01000,
    AMO_AND  = 5'b01100,
    AMO_MIN  = 5'b10000,
    AMO_MAX  = 5'b10100,
    AMO_MINU = 5'b11000,
    AMO_MAXU = 5'b11100
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amo_state_e;

  // true for codes that read, combine and write back unconditionally
  function automatic logic is_rmw(input logic [4:0] code);
    case (code)
      AMO_ADD, AMO_SWAP, AMO_XOR, AMO_OR, AMO_AND,
      AMO_MIN, AMO_MAX, AMO_MINU, AMO_MAXU: is_rmw = 1'b1;
      default:                              is_rmw = 1'b0;
    endcase
  endfunction

  function automatic logic is_known(input logic [4:0] code);
    is_known = is_rmw(code) || (code == AMO_LR) || (code == AMO_SC);
  endfunction

endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic in_read,
  output logic in_write,
  output logic in_done
);

  amo_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle     = (st_q == ST_IDLE);
  assign in_read  = (st_q == ST_READ);
  assign in_write = (st_q == ST_WRITE);
  assign in_done  = (st_q == ST_DONE);

  // R2
  read_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |=> in_write);
  // R2
  write_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |=> in_done);
  // R2
  start_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> in_read);

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [4:0]   code,
  input  logic [W-1:0] old_w,
  input  logic [W-1:0] src_w,
  output logic [W-1:0] new_w
);

  logic lt_s, lt_u;

  assign lt_s = $signed(old_w) < $signed(src_w);
  assign lt_u = old_w < src_w;

  always_comb begin
    case (code)
      AMO_ADD:          new_w = old_w + src_w;
      AMO_SWAP, AMO_SC: new_w = src_w;
      AMO_XOR:          new_w = old_w ^ src_w;
      AMO_OR:           new_w = old_w | src_w;
      AMO_AND:          new_w = old_w & src_w;
      AMO_MIN:          new_w = lt_s ? old_w : src_w;
      AMO_MAX:          new_w = lt_s ? src_w : old_w;
      AMO_MINU:         new_w = lt_u ? old_w : src_w;
      AMO_MAXU:         new_w = lt_u ? src_w : old_w;
      default:          new_w = old_w;
    endcase
  end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [AW-1:0] addr_in,
  output logic          hit
);

  logic          vld_q, vld_d;
  logic [AW-1:0] adr_q, adr_d;

  always_comb begin
    vld_d = vld_q;
    adr_d = adr_q;
    if (set_en) begin
      vld_d = 1'b1;
      adr_d = addr_in;
    end else if (clr_en) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (set_en) adr_q <= adr_d;
  end

  assign hit = vld_q && (adr_q == addr_in);

  // R9
  sc_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !vld_q);
  // R6
  lr_sets_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (vld_q && adr_q == $past(addr_in)));

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [4:0]      op_code,
  input  logic            op_aq,
  input  logic            op_rl,
  input  logic [XLEN-1:0] op_addr,
  input  logic [XLEN-1:0] op_src,
  input  logic [4:0]      op_rd,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [XLEN-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            op_done,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data
);

  localparam int EXT_W = XLEN - WORD_W;

  logic              idle, in_read, in_write, in_done, accept;
  logic [4:0]        code_q;
  logic [XLEN-1:0]   addr_q;
  logic [WORD_W-1:0] src_q;
  logic [4:0]        rd_q;
  logic [XLEN-1:0]   res_q, res_d;
  logic [XLEN-1:0]   old_ext;
  logic [WORD_W-1:0] new_w;
  logic              resv_hit, is_sc, is_lr;

  assign accept = op_valid && idle;
  assign is_sc  = (code_q == AMO_SC);
  assign is_lr  = (code_q == AMO_LR);

  // ordering hints and the upper rs2 bits take no part in the result
  logic unused_ign;
  generate
    if (EXT_W > 0) begin : g_wide
      assign old_ext    = {{EXT_W{mem_rdata[WORD_W-1]}}, mem_rdata};
      assign unused_ign = ^{op_aq, op_rl, op_src[XLEN-1:WORD_W]};
    end else begin : g_narrow
      assign old_ext    = mem_rdata;
      assign unused_ign = ^{op_aq, op_rl};
    end
  endgenerate

  amo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (op_valid),
    .idle     (idle),
    .in_read  (in_read),
    .in_write (in_write),
    .in_done  (in_done)
  );

  amo_alu #(.W(WORD_W)) u_alu (
    .code  (code_q),
    .old_w (mem_rdata),
    .src_w (src_q),
    .new_w (new_w)
  );

  amo_resv #(.AW(XLEN)) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (in_write && is_lr),
    .clr_en  (in_write && is_sc),
    .addr_in (addr_q),
    .hit     (resv_hit)
  );

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      code_q <= op_code;
      addr_q <= op_addr;
      src_q  <= op_src[WORD_W-1:0];
      rd_q   <= op_rd;
    end
  end

  always_comb begin
    res_d = res_q;
    if (in_write) begin
      if (is_sc) res_d = resv_hit ? '0 : XLEN'(1);
      else       res_d = old_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (in_write) res_q <= res_d;
  end

  assign op_ready  = idle;
  assign mem_rd_en = in_read;
  assign mem_wr_en = in_write && (is_rmw(code_q) || (is_sc && resv_hit));
  assign mem_addr  = addr_q;
  assign mem_wdata = new_w;
  assign op_done   = in_done;
  assign wb_en     = in_done && (rd_q != 5'd0) && is_known(code_q);
  assign wb_rd     = rd_q;
  assign wb_data   = res_q;

  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  // R2
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> op_done);
  // R10
  wb_nonzero_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (op_done && wb_rd != 5'd0));
  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  // R6
  lr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_write && is_lr) |-> !mem_wr_en);

endmodule

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic            op_ready;
  logic [4:0]      op_code = '0;
  logic            op_aq = 1'b0, op_rl = 1'b0;
  logic [XLEN-1:0] op_addr = '0, op_src = '0;
  logic [4:0]      op_rd = '0;
  logic            mem_rd_en, mem_wr_en;
  logic [XLEN-1:0] mem_addr;
  logic [31:0]     mem_wdata;
  logic [31:0]     mem_rdata;
  logic            op_done, wb_en;
  logic [4:0]      wb_rd;
  logic [XLEN-1:0] wb_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  amo_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_aq(op_aq), .op_rl(op_rl), .op_addr(op_addr),
    .op_src(op_src), .op_rd(op_rd), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .op_done(op_done), .wb_en(wb_en),
    .wb_rd(wb_rd), .wb_data(wb_data)
  );

  // bench memory: 16 words, one-cycle read latency, preload port
  logic [31:0] mem [16];
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    else if (mem_wr_en) mem[mem_addr[5:2]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[5:2]];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    pl_en = 1'b1; pl_idx = idx; pl_data = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [31:0] model(input logic [4:0] c, input logic [31:0] o, input logic [31:0] s);
    case (c)
      5'b00000: return o + s;
      5'b00001: return s;
      5'b00100: return o ^ s;
      5'b01100: return o & s;
      5'b01000: return o | s;
      5'b10000: return ($signed(o) <= $signed(s)) ? o : s;
      5'b10100: return ($signed(o) >= $signed(s)) ? o : s;
      5'b11000: return (o <= s) ? o : s;
      5'b11100: return (o >= s) ? o : s;
      default:  return o;
    endcase
  endfunction

  logic        r_wb_en;
  logic [63:0] r_wb;
  int          r_cyc;
  bit          r_early_wb, r_ready_hi;

  // called at a falling edge; returns at the falling edge where op_done is seen
  task automatic run_op(input logic [4:0] c, input logic [3:0] idx, input logic [63:0] s,
                        input logic [4:0] rd, input logic aq, input logic rl);
    op_valid = 1'b1; op_code = c; op_addr = {58'd0, idx, 2'b00};
    op_src = s; op_rd = rd; op_aq = aq; op_rl = rl;
    @(negedge clk);
    op_valid = 1'b0; op_code = 5'b11111; op_src = '1; op_rd = 5'd31;
    r_cyc = 1; r_early_wb = 0; r_ready_hi = 0;
    while (!op_done && r_cyc < 10) begin
      if (wb_en) r_early_wb = 1;
      if (op_ready) r_ready_hi = 1;
      @(negedge clk);
      r_cyc++;
    end
    r_wb_en = wb_en;
    r_wb = wb_data;
    @(negedge clk);
  endtask

  logic [31:0] vals [6];
  logic [4:0]  rmw_codes [9];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_ABCD;
    rmw_codes[0] = 5'b00001; rmw_codes[1] = 5'b00000; rmw_codes[2] = 5'b00100;
    rmw_codes[3] = 5'b01100; rmw_codes[4] = 5'b01000; rmw_codes[5] = 5'b10000;
    rmw_codes[6] = 5'b10100; rmw_codes[7] = 5'b11000; rmw_codes[8] = 5'b11100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", op_ready, 1);
    check("R1 rd_en", mem_rd_en, 0);
    check("R1 wr_en", mem_wr_en, 0);
    check("R1 done", op_done, 0);
    check("R1 wb_en", wb_en, 0);

    // R1 / R8: store-conditional with no reservation fails
    preload(4'd2, 32'hAAAA_5555);
    run_op(5'b00011, 4'd2, 64'h1111_2222, 5'd3, 0, 0);
    check("R1 R8 sc result", r_wb, 64'd1);
    check("R8 sc no write", mem[2], 32'hAAAA_5555);

    // R3 R4 R5 R2 R11: sweep of read-modify-write codes over value pairs
    for (int c = 0; c < 9; c++) begin
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          logic [3:0]  idx;
          logic [31:0] exp_new;
          idx = 4'((c * 36 + a * 6 + b) % 16);
          preload(idx, vals[a]);
          run_op(rmw_codes[c], idx, {32'hDEAD_BEEF, vals[b]}, 5'd7, 1'((a + b) % 2), 1'(b % 2));
          exp_new = model(rmw_codes[c], vals[a], vals[b]);
          check((c >= 5) ? "R4 stored" : "R3 stored", mem[idx], exp_new);
          check("R5 wb value", r_wb, sx(vals[a]));
          check("R5 wb enable", r_wb_en, 1);
          check("R2 latency", r_cyc, 3);
          check("R2 ready low", r_ready_hi, 0);
        end
      end
    end

    // R11: same operation with every aq/rl combination gives same result
    for (int q = 0; q < 4; q++) begin
      preload(4'd5, 32'hFFFF_FFF0);
      run_op(5'b00000, 4'd5, 64'h20, 5'd9, 1'(q / 2), 1'(q % 2));
      check("R11 aq rl mem", mem[5], 32'h0000_0010);
      check("R11 aq rl wb", r_wb, 64'hFFFF_FFFF_FFFF_FFF0);
      check("R11 aq rl latency", r_cyc, 3);
    end

    // R10: rd index 0 suppresses writeback, memory still updated
    preload(4'd6, 32'h0000_0100);
    run_op(5'b00000, 4'd6, 64'h5, 5'd0, 0, 0);
    check("R10 no wb_en", r_wb_en, 0);
    check("R10 no early wb", r_early_wb, 0);
    check("R10 mem updated", mem[6], 32'h0000_0105);

    // R6 R7 R9: reserve, succeed, then fail on reuse
    preload(4'd8, 32'h8765_4321);
    run_op(5'b00010, 4'd8, 64'h0, 5'd4, 0, 0);
    check("R6 lr value", r_wb, 64'hFFFF_FFFF_8765_4321);
    check("R6 lr no write", mem[8], 32'h8765_4321);
    run_op(5'b00011, 4'd8, 64'hCAFE_0000_0BAD_F00D, 5'd4, 0, 0);
    check("R7 sc success code", r_wb, 64'd0);
    check("R7 sc stored", mem[8], 32'h0BAD_F00D);
    run_op(5'b00011, 4'd8, 64'h1234, 5'd4, 0, 0);
    check("R9 second sc fails", r_wb, 64'd1);
    check("R9 no second write", mem[8], 32'h0BAD_F00D);

    // R8 R9: mismatched address fails and still clears
    preload(4'd9, 32'h0000_0009);
    run_op(5'b00010, 4'd8, 64'h0, 5'd4, 0, 0);
    run_op(5'b00011, 4'd9, 64'h77, 5'd4, 0, 0);
    check("R8 other addr fails", r_wb, 64'd1);
    check("R8 other addr no write", mem[9], 32'h0000_0009);
    run_op(5'b00011, 4'd8, 64'h77, 5'd4, 0, 0);
    check("R9 cleared by failed sc", r_wb, 64'd1);
    check("R9 no write after clear", mem[8], 32'h0BAD_F00D);

    // R7 R10: successful sc with rd 0 still writes
    run_op(5'b00010, 4'd10, 64'h0, 5'd1, 0, 0);
    run_op(5'b00011, 4'd10, 64'h4242, 5'd0, 0, 0);
    check("R7 R10 sc rd0 write", mem[10], 32'h0000_4242);
    check("R10 sc rd0 no wb", r_wb_en, 0);

    // R12: unsupported code
    preload(4'd11, 32'h5A5A_5A5A);
    run_op(5'b00101, 4'd11, 64'h1, 5'd2, 0, 0);
    check("R12 latency", r_cyc, 3);
    check("R12 no wb", r_wb_en, 0);
    check("R12 no write", mem[11], 32'h5A5A_5A5A);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule